// File: doc/BRIEF.md
# Word-Size-Adaptive Buffer with DMA Request Generation

This block is a first-in first-out buffer for one direction of a serial port. One fixed 128-bit store is laid out in one of two ways, chosen by the configured word size. For words of 4 to 8 bits it holds sixteen 8-bit entries. For words of 9 to 16 bits it holds eight 16-bit entries. Each word is right-justified on entry: bits above the word size are cleared, so they always read back as zero.

Data enters and leaves through valid/ready streams. A word moves on the write side when `in_valid` and `in_ready` are both high at a rising clock edge. A word moves on the read side when `out_valid` and `out_ready` are both high. The writer is back-pressured by `in_ready`, which falls when the buffer is full. The reader is never stalled beyond `out_valid` being low while the buffer is empty.

The block also drives the single and burst request lines for a DMA controller. A parameter chooses receive-side rules (requests track stored entries) or transmit-side rules (requests track free locations). The fill level, the empty and full flags, and a sticky overrun flag are plain status pins.

Top module: `flex_word_fifo`

## Requirements
- R1: With a word size of 4 to 8, the buffer holds 16 entries of 8 bits, and `full` rises when the 16th word is stored.
- R2: With a word size of 9 to 16, the buffer holds 8 entries of 16 bits, and `full` rises when the 8th word is stored.
- R3: Words come out in the order they were accepted. Each word is masked to the word size in force when it was written, and the bits above it read as zero. A word size below 4 acts as 4, and a word size above 16 acts as 16.
- R4: A write happens when `in_valid && in_ready`. A read happens when `out_valid && out_ready`. `out_valid` is high exactly when the buffer is not empty and no flush is taking place. A write and a read in the same cycle leave the fill level unchanged.
- R5: `fill` counts the stored entries from 0 up to the current depth (16 or 8). `empty` means fill is 0, and `full` means fill equals the current depth.
- R6: Asserting `in_valid` while `full` is high drops the word and sets `overrun`. The flag stays set until `ovr_clr` is high at a clock edge. If both happen in the same cycle, the clear wins.
- R7: In any cycle where the word size moves the buffer between the 8-bit and 16-bit layouts, `in_ready` and `out_valid` are low. In the next cycle the buffer is empty.
- R8: With receive-side rules (IS_TX=0), `dma_single` is high when fill is at least 1. `dma_burst` is high when `burst_thr` is nonzero and fill is at least `burst_thr`.
- R9: With transmit-side rules (IS_TX=1), free space is the current depth minus fill. `dma_single` is high when free space is at least 1. `dma_burst` is high when `burst_thr` is nonzero and free space is at least `burst_thr`.
- R10: Both request lines are combinational in the current fill level. They drop in the same cycle that their condition stops holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_size | input | 5 | Configured word size in bits |
| burst_thr | input | 5 | Burst request threshold in entries |
| ovr_clr | input | 1 | Clears the overrun flag |
| in_valid | input | 1 | Write-side word offered |
| in_ready | output | 1 | Write-side word can be taken |
| in_data | input | 16 | Write-side word, right-justified |
| out_valid | output | 1 | Read-side word available |
| out_ready | input | 1 | Read-side consumer takes the word |
| out_data | output | 16 | Read-side word, upper bits zero |
| fill | output | 5 | Number of stored entries |
| empty | output | 1 | No entries stored |
| full | output | 1 | Fill equals current depth |
| overrun | output | 1 | Sticky: a word was offered while full |
| dma_single | output | 1 | DMA single-transfer request |
| dma_burst | output | 1 | DMA burst-transfer request |

## Verification
A pointer that wraps at the wrong depth shows up at the ports within one full cycle of the buffer. Either `full` rises at the wrong count, or the scoreboard sees a word out of order the first time the read pointer passes the faulty wrap point. A wrong fill count shows up on `fill` and on the request lines in the cycle after the faulty update. A missed flush shows as a nonzero `fill` in the cycle right after the layout change. Lane mis-steering in the 16-bit layout corrupts the first wide word read back, where the scoreboard compares it.

// File: rtl/flexfifo_pkg.sv
package flexfifo_pkg;

  typedef enum logic {
    ORG_NARROW = 1'b0,
    ORG_WIDE   = 1'b1
  } org_e;

endpackage

// File: rtl/flexfifo_ptrs.sv
module flexfifo_ptrs
  import flexfifo_pkg::*;
#(
  parameter int DEPTH_N = 16,
  parameter int RATIO   = 2,
  localparam int CNT_W  = $clog2(DEPTH_N + 1),
  localparam int PTR_W  = $clog2(DEPTH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  org_e             org,
  input  logic             flush,
  input  logic             wr_fire,
  input  logic             rd_fire,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  localparam int DEPTH_WIDE = DEPTH_N / RATIO;

  logic [CNT_W-1:0] depth_cur;
  logic [PTR_W-1:0] ptr_mask;

  assign depth_cur = (org == ORG_WIDE) ? CNT_W'(DEPTH_WIDE) : CNT_W'(DEPTH_N);
  assign ptr_mask  = PTR_W'(depth_cur - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_fire) wptr <= (wptr + PTR_W'(1)) & ptr_mask;
      if (rd_fire) rptr <= (rptr + PTR_W'(1)) & ptr_mask;
      case ({wr_fire, rd_fire})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign empty = (count == '0);
  assign full  = (count == depth_cur);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth_cur);

  p_wide_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (org == ORG_WIDE) |-> (int'(wptr) < DEPTH_WIDE && int'(rptr) < DEPTH_WIDE));

endmodule

// File: rtl/flexfifo_store.sv
module flexfifo_store #(
  parameter int STORE_BITS = 128,
  parameter int NARROW_W   = 8,
  parameter int WIDE_W     = 16,
  localparam int LANES     = STORE_BITS / NARROW_W,
  localparam int RATIO     = WIDE_W / NARROW_W,
  localparam int PTR_W     = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [WIDE_W-1:0] wdata,
  input  logic [PTR_W-1:0]  rptr,
  output logic [WIDE_W-1:0] rdata
);

  logic [STORE_BITS-1:0] mem_q;
  logic [LANES-1:0]      lane_we;
  logic [STORE_BITS-1:0] lane_din;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int SLOT = g / RATIO;
    localparam int PART = g % RATIO;
    logic hit;
    assign hit = wide ? (int'(wptr) == SLOT) : (int'(wptr) == g);
    assign lane_we[g] = wr_en && hit;
    assign lane_din[g*NARROW_W +: NARROW_W] =
      wide ? wdata[PART*NARROW_W +: NARROW_W] : wdata[NARROW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_we[l]) mem_q[l*NARROW_W +: NARROW_W] <= lane_din[l*NARROW_W +: NARROW_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (wide) begin
      for (int k = 0; k < RATIO; k++) begin
        rdata[k*NARROW_W +: NARROW_W] = mem_q[(int'(rptr)*RATIO + k)*NARROW_W +: NARROW_W];
      end
    end else begin
      rdata[NARROW_W-1:0] = mem_q[int'(rptr)*NARROW_W +: NARROW_W];
    end
  end

  p_one_lane_narrow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide) |-> $countones(lane_we) <= 1);

endmodule

// File: rtl/flexfifo_dma.sv
module flexfifo_dma
  import flexfifo_pkg::*;
#(
  parameter int IS_TX   = 0,
  parameter int DEPTH_N = 16,
  parameter int RATIO   = 2,
  localparam int CNT_W  = $clog2(DEPTH_N + 1)
) (
  input  org_e             org,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thr,
  output logic             single_req,
  output logic             burst_req
);

  logic [CNT_W-1:0] depth_cur;
  logic [CNT_W-1:0] level;

  assign depth_cur = (org == ORG_WIDE) ? CNT_W'(DEPTH_N / RATIO) : CNT_W'(DEPTH_N);

  if (IS_TX != 0) begin : g_tx
    assign level = depth_cur - count;
  end else begin : g_rx
    assign level = count;
  end

  assign single_req = (level != '0);
  assign burst_req  = (thr != '0) && (level >= thr);

endmodule

// File: rtl/flex_word_fifo.sv
module flex_word_fifo
  import flexfifo_pkg::*;
#(
  parameter int STORE_BITS = 128,
  parameter int NARROW_W   = 8,
  parameter int WIDE_W     = 16,
  parameter int MIN_WS     = 4,
  parameter int IS_TX      = 0,
  localparam int DEPTH_N   = STORE_BITS / NARROW_W,
  localparam int RATIO     = WIDE_W / NARROW_W,
  localparam int CNT_W     = $clog2(DEPTH_N + 1),
  localparam int PTR_W     = $clog2(DEPTH_N),
  localparam int WSZ_W     = $clog2(WIDE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WSZ_W-1:0]  word_size,
  input  logic [CNT_W-1:0]  burst_thr,
  input  logic              ovr_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIDE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_data,
  output logic [CNT_W-1:0]  fill,
  output logic              empty,
  output logic              full,
  output logic              overrun,
  output logic              dma_single,
  output logic              dma_burst
);

  logic [WSZ_W-1:0]  ws_c;
  logic [WIDE_W-1:0] wmask;
  org_e              org_want, org_q;
  logic              org_chg;
  logic              wr_fire, rd_fire;
  logic [PTR_W-1:0]  wptr, rptr;

  // Out-of-range word sizes are pinned to the supported span.
  always_comb begin
    if (int'(word_size) < MIN_WS)      ws_c = WSZ_W'(MIN_WS);
    else if (int'(word_size) > WIDE_W) ws_c = WSZ_W'(WIDE_W);
    else                               ws_c = word_size;
  end

  always_comb begin
    for (int i = 0; i < WIDE_W; i++) wmask[i] = (i < int'(ws_c));
  end

  assign org_want = (int'(ws_c) > NARROW_W) ? ORG_WIDE : ORG_NARROW;
  assign org_chg  = (org_want != org_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) org_q <= ORG_NARROW;
    else        org_q <= org_want;
  end

  assign in_ready  = !full && !org_chg;
  assign out_valid = !empty && !org_chg;
  assign wr_fire   = in_valid && in_ready;
  assign rd_fire   = out_valid && out_ready;

  flexfifo_ptrs #(.DEPTH_N(DEPTH_N), .RATIO(RATIO)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .org     (org_q),
    .flush   (org_chg),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .wptr    (wptr),
    .rptr    (rptr),
    .count   (fill),
    .empty   (empty),
    .full    (full)
  );

  flexfifo_store #(.STORE_BITS(STORE_BITS), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wide  (org_q == ORG_WIDE),
    .wr_en (wr_fire),
    .wptr  (wptr),
    .wdata (in_data & wmask),
    .rptr  (rptr),
    .rdata (out_data)
  );

  flexfifo_dma #(.IS_TX(IS_TX), .DEPTH_N(DEPTH_N), .RATIO(RATIO)) u_dma (
    .org        (org_q),
    .count      (fill),
    .thr        (burst_thr),
    .single_req (dma_single),
    .burst_req  (dma_burst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 overrun <= 1'b0;
    else if (ovr_clr)           overrun <= 1'b0;
    else if (in_valid && full)  overrun <= 1'b1;
  end

  p_drop_sets_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !ovr_clr) |=> overrun);

  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    org_chg |=> (fill == '0));

  p_full_holds_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready && !org_chg) |=> $stable(fill));

  if (IS_TX != 0) begin : g_chk_tx
    p_tx_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_single == !full);
  end else begin : g_chk_rx
    p_rx_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_single == !empty);
  end

endmodule

// File: tb/test_flex_word_fifo.sv
module test_flex_word_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  word_size = 5'd8;
  logic [4:0]  burst_thr = 5'd4;
  logic        ovr_clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_ready = 1'b0;

  logic        in_ready, out_valid, empty, full, overrun, dma_single, dma_burst;
  logic [15:0] out_data;
  logic [4:0]  fill;
  logic        t_in_ready, t_out_valid, t_empty, t_full, t_overrun, t_single, t_burst;
  logic [15:0] t_out_data;
  logic [4:0]  t_fill;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  flex_word_fifo #(.IS_TX(0)) i_flex_word_fifo (
    .clk(clk), .rst_n(rst_n), .word_size(word_size), .burst_thr(burst_thr),
    .ovr_clr(ovr_clr), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .fill(fill),
    .empty(empty), .full(full), .overrun(overrun), .dma_single(dma_single),
    .dma_burst(dma_burst)
  );

  flex_word_fifo #(.IS_TX(1)) i_flex_word_fifo_tx (
    .clk(clk), .rst_n(rst_n), .word_size(word_size), .burst_thr(burst_thr),
    .ovr_clr(ovr_clr), .in_valid(in_valid), .in_ready(t_in_ready), .in_data(in_data),
    .out_valid(t_out_valid), .out_ready(out_ready), .out_data(t_out_data), .fill(t_fill),
    .empty(t_empty), .full(t_full), .overrun(t_overrun), .dma_single(t_single),
    .dma_burst(t_burst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mask_for(input logic [4:0] ws);
    int w;
    w = (ws < 4) ? 4 : (ws > 16) ? 16 : int'(ws);
    return 16'((32'd1 << w) - 1);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Driver: offers one word; an accepted word becomes an expected item.
  task automatic wr(input logic [15:0] d, input bit rd_too = 1'b0);
    in_valid = 1'b1;
    in_data = d;
    out_ready = rd_too;
    #2;
    if (in_ready) exp_q.push_back(d & mask_for(word_size));
    step();
    in_valid = 1'b0;
    out_ready = 1'b0;
    #1;
  endtask

  task automatic drain(input int n);
    out_ready = 1'b1;
    repeat (n) step();
    out_ready = 1'b0;
    #1;
  endtask

  // Monitor: compares every word that leaves the RX instance.
  initial begin
    forever begin
      bit fire;
      logic [15:0] od;
      @(negedge clk);
      #3;
      fire = out_valid && out_ready;
      od = out_data;
      @(posedge clk);
      if (fire) begin
        if (exp_q.size() == 0) begin
          chk("R4 read with nothing expected", 1, 0);
        end else begin
          chk("R3 data order/mask", int'(od), int'(exp_q.pop_front()));
        end
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // Reset state
    chk("R5 reset fill", fill, 0);
    chk("R5 reset empty", empty, 1);
    chk("R6 reset overrun", overrun, 0);
    chk("R4 reset out_valid", out_valid, 0);
    chk("R8 reset rx single", dma_single, 0);
    chk("R9 reset tx single", t_single, 1);
    chk("R9 reset tx burst", t_burst, 1);

    // R1: narrow layout fills to 16; R8/R9/R10 request levels per step
    for (int k = 1; k <= 16; k++) begin
      wr(16'h0030 + 16'(k));
      chk("R5 fill narrow", fill, k);
      chk("R8 rx single", dma_single, 1);
      chk("R8 rx burst", dma_burst, int'(k >= 4));
      chk("R9 tx single", t_single, int'(k < 16));
      chk("R10 tx burst", t_burst, int'((16 - k) >= 4));
      chk("R1 full", full, int'(k == 16));
    end
    // R6: offered while full, dropped, overrun raised
    wr(16'h00EE);
    chk("R6 overrun set", overrun, 1);
    chk("R6 fill unchanged", fill, 16);
    ovr_clr = 1'b1;
    step();
    ovr_clr = 1'b0;
    #1;
    chk("R6 overrun cleared", overrun, 0);
    drain(16);
    chk("R4 empty after drain", empty, 1);
    chk("R3 scoreboard drained", exp_q.size(), 0);

    // R3: right-justification and clamping
    word_size = 5'd5;
    wr(16'h00FF);
    wr(16'hFF3A);
    word_size = 5'd2;
    wr(16'h00FF);
    word_size = 5'd7;
    drain(3);
    chk("R3 scoreboard after mask", exp_q.size(), 0);

    // R7: layout change flushes stored words
    word_size = 5'd8;
    wr(16'h0011); wr(16'h0022); wr(16'h0033);
    chk("R5 fill before flush", fill, 3);
    word_size = 5'd12;
    #2;
    chk("R7 in_ready during change", in_ready, 0);
    chk("R7 out_valid during change", out_valid, 0);
    exp_q.delete();
    step();
    #1;
    chk("R7 fill after flush", fill, 0);
    chk("R7 empty after flush", empty, 1);

    // R2: wide layout fills to 8
    for (int k = 1; k <= 8; k++) begin
      wr(16'hA000 + 16'(k * 16'h0111));
      chk("R5 fill wide", fill, k);
      chk("R2 full", full, int'(k == 8));
      chk("R9 tx single wide", t_single, int'(k < 8));
      chk("R9 tx burst wide", t_burst, int'((8 - k) >= 4));
    end
    wr(16'h0555);
    chk("R6 overrun wide", overrun, 1);
    chk("R2 fill capped", fill, 8);
    ovr_clr = 1'b1;
    wr(16'h0556);
    ovr_clr = 1'b0;
    chk("R6 clear wins", overrun, 0);
    drain(8);
    chk("R3 wide drained", exp_q.size(), 0);

    // R4: simultaneous write and read keeps fill
    word_size = 5'd16;
    wr(16'hBEEF);
    wr(16'hCAFE, 1'b1);
    chk("R4 simultaneous fill", fill, 1);
    wr(16'h1234);

    // R10: burst withdrawn in the cycle the level drops
    burst_thr = 5'd2;
    #1;
    chk("R10 rx burst at 2", dma_burst, 1);
    drain(1);
    chk("R10 rx burst withdrawn", dma_burst, 0);
    chk("R8 rx single still", dma_single, 1);
    burst_thr = 5'd0;
    #1;
    chk("R8 zero threshold no burst", dma_burst, 0);
    chk("R9 zero threshold no tx burst", t_burst, 0);

    // R7: wide back to narrow with an entry stored
    word_size = 5'd7;
    exp_q.delete();
    step();
    #1;
    chk("R7 flush wide to narrow", fill, 0);
    chk("R8 rx single after flush", dma_single, 0);
    chk("R9 tx single after flush", t_single, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule